// File: doc/BRIEF.md
# Processor Exception Entry Unit

This block performs the architectural state update a processor core needs when it takes an exception. Each cycle it looks at a vector of exception requests. It picks one by fixed priority and gates the asynchronous ones with the external-interrupt-enable bit of the incoming machine state. It then commits, in one clock edge, the save/restore pair, the new machine state, the data fault status and the data fault address. In the same cycle it presents the next fetch address.

All 64-bit values use big-endian bit numbering: bit 0 is the most significant bit, so big-endian bit n sits at vector index 63-n. The 32-bit fault status uses the same convention, so its bit n sits at index 31-n. Pipeline flushing, fault detection and the return-from-exception path belong to the surrounding core.

Top module: `exc_entry_unit`

## Requirements
- R1: Request bit k of `req_i` selects this cause: 0 machine check, 1 instruction storage, 2 program, 3 data storage, 4 alignment, 5 FP unavailable, 6 system call, 7 FP assist, 8 external, 9 decrementer. When several eligible requests are present, the lowest index wins.
- R2: External (bit 8) and decrementer (bit 9) requests are eligible only when `msr_i` bit 48 (interrupt enable) is 1. With no eligible request, no exception is taken and all committed registers hold.
- R3: The new MSR is the old MSR with bits 45, 48, 49, 50, 52, 53, 54, 55, 58, 59 and 62 cleared and bit 0 set. All other bits are kept.
- R4: SRR1 is the old MSR masked to bits 0-32, 37-41 and 48-63, ORed with the cause bits given in R8 and R10.
- R5: SRR0 is `pc_i`, except for system call, where it is `pc_i + 4`.
- R6: The next fetch address is the cause offset (0x200, 0x400, 0x700, 0x300, 0x600, 0x800, 0xC00, 0xE00, 0x500, 0x900 for causes 0..9) plus a base. The base is all ones in bits 0-43 when bit 57 of the new MSR is 1, and zero otherwise.
- R7: A data storage fault writes DAR with `ea_i`. It writes the fault status with one reason bit, chosen by `stor_why_i` as follows: 0 direct-store error to bit 0, 1 translation miss to bit 1, 2 protection to bit 4, 3 segment miss to bit 10, 4 external-access violation to bit 5, 5 external access disabled to bit 11. Bit 6 is ORed in when `store_i` is 1.
- R8: An instruction storage fault sets one SRR1 bit, chosen by `stor_why_i` as follows: 0 to bit 35, 1 to bit 33, 2 to bit 36, 3 to bit 42. Codes 4 and above set none.
- R9: An alignment fault writes DAR with `ea_i` and the fault status with zero. Every cause other than data storage and alignment leaves DAR and the fault status unchanged.
- R10: A program exception sets SRR1 bit 43 + `prog_why_i`: 0 FP enabled, 1 illegal or unsupported instruction, 2 privileged, 3 trap.
- R11: `dbl_fault_o` pulses with `take_o` when old MSR bit 62 (recoverable) was 0.
- R12: All outputs change one clock after the request cycle. In that cycle `take_o` is high for one cycle per taken request, and `next_pc_o` is valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 10 | Exception request per cause |
| pc_i | input | 64 | Address of the current instruction |
| msr_i | input | 64 | Current machine state |
| ea_i | input | 64 | Fault effective address |
| store_i | input | 1 | Faulting access was a store |
| stor_why_i | input | 3 | Storage fault reason code |
| prog_why_i | input | 2 | Program exception reason code |
| take_o | output | 1 | Exception committed this cycle |
| srr0_o | output | 64 | Saved return address |
| srr1_o | output | 64 | Saved machine state with cause bits |
| msr_o | output | 64 | New machine state |
| dsisr_o | output | 32 | Data fault status |
| dar_o | output | 64 | Data fault address |
| next_pc_o | output | 64 | Exception vector fetch address |
| dbl_fault_o | output | 1 | Exception taken while not recoverable |

## Verification
Each cause is driven alone under all-ones, all-zeros and two alternating MSR patterns. This separates the cleared, forced, kept and masked MSR bits, and shows the effect of the prefix bit and the recoverable bit. The same sweep with interrupt enable clear tells the gated asynchronous causes from the synchronous ones. Every pair of causes is then raised together, which exposes any priority inversion. Reason-code sweeps for data storage, instruction storage and program faults, with loads and stores, pin each status and SRR1 bit to its position. These sweeps also show that non-data causes leave DAR and the status register untouched.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XLEN    = 64;
  localparam int DSW     = 32;
  localparam int NCAUSE  = 10;
  localparam int CW      = $clog2(NCAUSE);

  typedef enum logic [CW-1:0] {
    C_MCHK  = 4'd0, C_ISTOR = 4'd1, C_PROG = 4'd2, C_DSTOR = 4'd3,
    C_ALIGN = 4'd4, C_FPUN  = 4'd5, C_SYSC = 4'd6, C_FPAS  = 4'd7,
    C_EXT   = 4'd8, C_DEC   = 4'd9
  } cause_e;

  // big-endian bit numbers
  localparam int M_SF = 0, M_POW = 45, M_EE = 48, M_PR = 49, M_FP = 50;
  localparam int M_FE0 = 52, M_SE = 53, M_BE = 54, M_FE1 = 55, M_IP = 57;
  localparam int M_IR = 58, M_DR = 59, M_RI = 62;

  function automatic int bx(int n);
    return XLEN - 1 - n;
  endfunction

  function automatic int dx(int n);
    return DSW - 1 - n;
  endfunction

  function automatic logic [XLEN-1:0] msr_clr_mask();
    logic [XLEN-1:0] m;
    m = '0;
    m[bx(M_POW)] = 1'b1; m[bx(M_EE)] = 1'b1; m[bx(M_PR)] = 1'b1;
    m[bx(M_FP)]  = 1'b1; m[bx(M_FE0)] = 1'b1; m[bx(M_SE)] = 1'b1;
    m[bx(M_BE)]  = 1'b1; m[bx(M_FE1)] = 1'b1; m[bx(M_IR)] = 1'b1;
    m[bx(M_DR)]  = 1'b1; m[bx(M_RI)] = 1'b1;
    return m;
  endfunction

  function automatic logic [XLEN-1:0] srr1_keep_mask();
    logic [XLEN-1:0] m;
    for (int n = 0; n < XLEN; n++)
      m[bx(n)] = (n <= 32) || (n >= 37 && n <= 41) || (n >= 48);
    return m;
  endfunction

  function automatic logic [XLEN-1:0] vec_off(cause_e c);
    case (c)
      C_MCHK:  return XLEN'(12'h200);
      C_DSTOR: return XLEN'(12'h300);
      C_ISTOR: return XLEN'(12'h400);
      C_EXT:   return XLEN'(12'h500);
      C_ALIGN: return XLEN'(12'h600);
      C_PROG:  return XLEN'(12'h700);
      C_FPUN:  return XLEN'(12'h800);
      C_DEC:   return XLEN'(12'h900);
      C_SYSC:  return XLEN'(12'hC00);
      C_FPAS:  return XLEN'(12'hE00);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
  parameter int N  = 10,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--)
      if (req_i[k]) idx_o = IW'(k);
  end
  assign any_o = |req_i;
endmodule

// File: rtl/exc_state_calc.sv
module exc_state_calc
  import exc_entry_pkg::*;
#(
  parameter int PFX_BITS  = 44,
  parameter int SYSC_STEP = 4
) (
  input  cause_e          cause_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] msr_i,
  input  logic            store_i,
  input  logic [2:0]      stor_why_i,
  input  logic [1:0]      prog_why_i,
  output logic [XLEN-1:0] srr0_o,
  output logic [XLEN-1:0] srr1_o,
  output logic [XLEN-1:0] msr_o,
  output logic [XLEN-1:0] next_pc_o,
  output logic [DSW-1:0]  dsisr_o,
  output logic            fault_we_o
);
  localparam logic [XLEN-1:0] CLR  = msr_clr_mask();
  localparam logic [XLEN-1:0] KEEP = srr1_keep_mask();
  localparam logic [XLEN-1:0] HI   = ~((XLEN'(1) << (XLEN - PFX_BITS)) - XLEN'(1));

  logic [XLEN-1:0] base;

  always_comb begin
    msr_o      = (msr_i & ~CLR) | (XLEN'(1) << bx(M_SF));
    srr1_o     = msr_i & KEEP;
    srr0_o     = pc_i;
    dsisr_o    = '0;
    fault_we_o = 1'b0;
    case (cause_i)
      C_ISTOR: begin
        case (stor_why_i)
          3'd0: srr1_o[bx(35)] = 1'b1;
          3'd1: srr1_o[bx(33)] = 1'b1;
          3'd2: srr1_o[bx(36)] = 1'b1;
          3'd3: srr1_o[bx(42)] = 1'b1;
          default: ;
        endcase
      end
      C_PROG: srr1_o[bx(43) - int'(prog_why_i)] = 1'b1;
      C_DSTOR: begin
        fault_we_o = 1'b1;
        case (stor_why_i)
          3'd0: dsisr_o[dx(0)]  = 1'b1;
          3'd1: dsisr_o[dx(1)]  = 1'b1;
          3'd2: dsisr_o[dx(4)]  = 1'b1;
          3'd3: dsisr_o[dx(10)] = 1'b1;
          3'd4: dsisr_o[dx(5)]  = 1'b1;
          3'd5: dsisr_o[dx(11)] = 1'b1;
          default: ;
        endcase
        dsisr_o[dx(6)] = store_i;
      end
      C_ALIGN: fault_we_o = 1'b1;
      C_SYSC:  srr0_o = pc_i + XLEN'(SYSC_STEP);
      default: ;
    endcase
    base      = msr_o[bx(M_IP)] ? HI : '0;
    next_pc_o = base + vec_off(cause_i);
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int PFX_BITS  = 44,
  parameter int SYSC_STEP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCAUSE-1:0] req_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   msr_i,
  input  logic [XLEN-1:0]   ea_i,
  input  logic              store_i,
  input  logic [2:0]        stor_why_i,
  input  logic [1:0]        prog_why_i,
  output logic              take_o,
  output logic [XLEN-1:0]   srr0_o,
  output logic [XLEN-1:0]   srr1_o,
  output logic [XLEN-1:0]   msr_o,
  output logic [DSW-1:0]    dsisr_o,
  output logic [XLEN-1:0]   dar_o,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              dbl_fault_o
);
  logic [NCAUSE-1:0] elig;
  logic              hit;
  logic [CW-1:0]     idx;
  cause_e            cause;
  logic [XLEN-1:0]   srr0_d, srr1_d, msr_d, npc_d;
  logic [DSW-1:0]    dsisr_d;
  logic              fwe;

  // asynchronous causes wait for interrupt enable
  always_comb begin
    elig = req_i;
    elig[C_EXT] = req_i[C_EXT] & msr_i[bx(M_EE)];
    elig[C_DEC] = req_i[C_DEC] & msr_i[bx(M_EE)];
  end

  exc_prio_pick #(.N(NCAUSE), .IW(CW)) u_pick (
    .req_i(elig), .any_o(hit), .idx_o(idx)
  );

  assign cause = cause_e'(idx);

  exc_state_calc #(.PFX_BITS(PFX_BITS), .SYSC_STEP(SYSC_STEP)) u_calc (
    .cause_i(cause), .pc_i(pc_i), .msr_i(msr_i), .store_i(store_i),
    .stor_why_i(stor_why_i), .prog_why_i(prog_why_i),
    .srr0_o(srr0_d), .srr1_o(srr1_d), .msr_o(msr_d), .next_pc_o(npc_d),
    .dsisr_o(dsisr_d), .fault_we_o(fwe)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_o <= 1'b0; dbl_fault_o <= 1'b0;
      srr0_o <= '0; srr1_o <= '0; msr_o <= '0; next_pc_o <= '0;
      dsisr_o <= '0; dar_o <= '0;
    end else begin
      take_o      <= hit;
      dbl_fault_o <= hit & ~msr_i[bx(M_RI)];
      if (hit) begin
        srr0_o    <= srr0_d;
        srr1_o    <= srr1_d;
        msr_o     <= msr_d;
        next_pc_o <= npc_d;
        if (fwe) begin
          dsisr_o <= dsisr_d;
          dar_o   <= ea_i;
        end
      end
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_entry_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NCAUSE-1:0] req_i,
  input logic [XLEN-1:0]   pc_i,
  input logic [XLEN-1:0]   msr_i,
  input logic              take_o,
  input logic [XLEN-1:0]   srr0_o,
  input logic [XLEN-1:0]   msr_o,
  input logic [DSW-1:0]    dsisr_o,
  input logic [XLEN-1:0]   dar_o,
  input logic [XLEN-1:0]   next_pc_o,
  input logic              dbl_fault_o
);
  a_r2_take_needs_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> ($past(|req_i[7:0]) || ($past(msr_i[bx(M_EE)]) && $past(|req_i[9:8]))));

  a_r3_msr_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (msr_o[bx(M_SF)] && !msr_o[bx(M_EE)] && !msr_o[bx(M_RI)]));

  a_r5_srr0_from_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (srr0_o == $past(pc_i) || srr0_o == $past(pc_i) + 64'd4));

  a_r6_vector_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (next_pc_o[7:0] == 8'h00 && next_pc_o[19:12] == 8'h00));

  a_r9_fault_regs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> ($stable(dar_o) && $stable(dsisr_o)));

  a_r11_double_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbl_fault_o |-> (take_o && !$past(msr_i[bx(M_RI)])));
endmodule

bind exc_entry_unit exc_entry_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .pc_i(pc_i), .msr_i(msr_i),
  .take_o(take_o), .srr0_o(srr0_o), .msr_o(msr_o), .dsisr_o(dsisr_o),
  .dar_o(dar_o), .next_pc_o(next_pc_o), .dbl_fault_o(dbl_fault_o)
);

// File: tb/exc_entry_unit_test.sv
module exc_entry_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [9:0]  req_i = '0;
  logic [63:0] pc_i = '0, msr_i = '0, ea_i = '0;
  logic        store_i = 1'b0;
  logic [2:0]  stor_why_i = '0;
  logic [1:0]  prog_why_i = '0;
  logic        take_o, dbl_fault_o;
  logic [63:0] srr0_o, srr1_o, msr_o, dar_o, next_pc_o;
  logic [31:0] dsisr_o;

  int tests = 0, fails = 0;
  logic [63:0] e_srr0 = '0, e_srr1 = '0, e_msr = '0, e_dar = '0, e_npc = '0;
  logic [31:0] e_dsisr = '0;

  always #4 clk_i = ~clk_i;

  exc_entry_unit uut (.*);

  initial begin
    #1600000;
    tests++; fails++;
    $display("FAIL watchdog: act=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic logic [63:0] bb(int n); return 64'd1 << (63 - n); endfunction
  function automatic logic [31:0] db(int n); return 32'd1 << (31 - n); endfunction

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", r, act, exp);
    end
  endtask

  // one request cycle, then check the commit cycle
  task automatic run(logic [9:0] rq, logic [63:0] pc, logic [63:0] m, logic [63:0] ea,
                     logic st, logic [2:0] sw, logic [1:0] pw);
    logic [9:0] el;
    int w;
    logic [63:0] keep, clr;
    logic [11:0] offs [10];
    offs = '{12'h200, 12'h400, 12'h700, 12'h300, 12'h600, 12'h800, 12'hC00, 12'hE00, 12'h500, 12'h900};
    req_i = rq; pc_i = pc; msr_i = m; ea_i = ea; store_i = st;
    stor_why_i = sw; prog_why_i = pw;
    el = rq;
    if (!m[63-48]) el[9:8] = 2'b00;
    w = -1;
    for (int k = 9; k >= 0; k--) if (el[k]) w = k;
    @(negedge clk_i);
    if (w < 0) begin
      chk("R2 no take", 64'(take_o), 64'd0);
      chk("R2 srr0 held", srr0_o, e_srr0);
      chk("R9 dar held", dar_o, e_dar);
    end else begin
      clr = bb(45)|bb(48)|bb(49)|bb(50)|bb(52)|bb(53)|bb(54)|bb(55)|bb(58)|bb(59)|bb(62);
      e_msr = (m & ~clr) | bb(0);
      keep = '0;
      for (int n = 0; n < 64; n++)
        if (n <= 32 || (n >= 37 && n <= 41) || n >= 48) keep |= bb(n);
      e_srr1 = m & keep;
      e_srr0 = (w == 6) ? pc + 64'd4 : pc;
      if (w == 1) case (sw)
        3'd0: e_srr1 |= bb(35);
        3'd1: e_srr1 |= bb(33);
        3'd2: e_srr1 |= bb(36);
        3'd3: e_srr1 |= bb(42);
        default: ;
      endcase
      if (w == 2) e_srr1 |= bb(43 + int'(pw));
      if (w == 3) begin
        e_dar = ea;
        case (sw)
          3'd0: e_dsisr = db(0);
          3'd1: e_dsisr = db(1);
          3'd2: e_dsisr = db(4);
          3'd3: e_dsisr = db(10);
          3'd4: e_dsisr = db(5);
          3'd5: e_dsisr = db(11);
          default: e_dsisr = '0;
        endcase
        if (st) e_dsisr |= db(6);
      end
      if (w == 4) begin e_dar = ea; e_dsisr = '0; end
      e_npc = (e_msr[63-57] ? {44'hFFFFFFFFFFF, 20'h0} : 64'd0) + 64'(offs[w]);
      chk("R12 take", 64'(take_o), 64'd1);
      chk("R3 msr", msr_o, e_msr);
      chk("R4 R8 R10 srr1", srr1_o, e_srr1);
      chk("R5 srr0", srr0_o, e_srr0);
      chk("R1 R6 next pc", next_pc_o, e_npc);
      chk("R11 double fault", 64'(dbl_fault_o), 64'(!m[63-62]));
    end
    chk("R7 R9 dar", dar_o, e_dar);
    chk("R7 R9 dsisr", 64'(dsisr_o), 64'(e_dsisr));
    req_i = '0;
    @(negedge clk_i);
    chk("R12 single pulse", 64'(take_o), 64'd0);
  endtask

  initial begin
    logic [63:0] pats [4];
    pats = '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'hA5A5_5A5A_C3C3_3C3C, 64'h5A5A_A5A5_3C3C_C3C3};
    #3;
    chk("R12 reset take", 64'(take_o), 64'd0);
    chk("R12 reset srr0", srr0_o, 64'd0);
    chk("R12 reset npc", next_pc_o, 64'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    // each cause alone, several states and reasons
    for (int c = 0; c < 10; c++)
      for (int p = 0; p < 4; p++)
        run(10'd1 << c, 64'h0000_1234_5678_9AB0 + 64'(c * 16 + p * 4), pats[p],
            64'hDEAD_0000_0000_0000 | 64'(c * 8 + p), p[0], 3'(c + p), 2'(p));
    // gating with interrupt enable clear, then set
    run(10'b11_0000_0000, 64'h100, 64'h0, 64'h7, 1'b0, 3'd0, 2'd0);
    run(10'b10_0000_0000, 64'h104, bb(48) | bb(62), 64'h7, 1'b0, 3'd0, 2'd0);
    // priority over every pair
    for (int i = 0; i < 10; i++)
      for (int j = i + 1; j < 10; j++)
        run((10'd1 << i) | (10'd1 << j), 64'h2000 + 64'(i * 64 + j * 4),
            bb(48) | bb(62) | bb(57), 64'hBEEF_0000 + 64'(i * 16 + j), 1'b1, 3'd2, 2'd1);
    // reason sweeps
    for (int s = 0; s < 8; s++)
      for (int st = 0; st < 2; st++)
        run(10'b00_0000_1000, 64'h3000, bb(62), 64'hCAFE_0000 + 64'(s), st[0], 3'(s), 2'd0);
    for (int s = 0; s < 8; s++)
      run(10'b00_0000_0010, 64'h4000, ~64'h0, 64'h0, 1'b0, 3'(s), 2'd0);
    for (int q = 0; q < 4; q++)
      run(10'b00_0000_0100, 64'h5000, 64'h0, 64'h0, 1'b0, 3'd0, 2'(q));
    run(10'b00_0001_0000, 64'h6000, bb(62), 64'h1234_5677, 1'b1, 3'd1, 2'd0);
    run(10'b00_0100_0000, 64'hFFFF_FFFF_FFFF_FFFC, bb(62), 64'h0, 1'b0, 3'd0, 2'd0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule